// File: doc/BRIEF.md
# Clocked Serial Port with Block Transfer

This block is an 8-bit synchronous serial port with separate data-out, data-in and clock lines. A small register port sets it up: a control register, a baud divider, a bit counter and the data shift register. When the port is the clock master, it makes the serial clock from the system clock through its own 8-bit divider. When it is a slave, it takes the clock from outside and passes clock and data through two-flop synchronisers before it detects edges.

Software picks the bit order (most or least significant first), loads the number of bits to move, writes the first byte and sets the run bit. The port then shifts every programmed bit back to back. Transmit data changes on falling clock edges and receive data is sampled on rising edges. Once the last bit completes, hardware clears the run bit and raises a sticky done flag, which is also the interrupt. In byte-pause mode the port stops after every eighth bit and holds the clock idle. It waits there until software reads the received byte, writes the next one and sets the run bit again.

Top module: `clkser_port`

## Requirements
- R1: Reset state. The control register reads 0, the serial clock output is 1, the clock output enable is 0, the serial data output is 1 and the interrupt is 0.
- R2: Register map, read back combinationally.
  - Address 0 is control: bit0 run, bit1 master, bit2 msb-first, bit3 byte-pause, bit7 done.
  - Address 1 is the baud divider N.
  - Address 2 is the remaining bit count minus one.
  - Address 3 is the data shift register.
- R3: In master mode the clock output enable is 1 and the clock idles high whenever run is 0. While running, each clock half-period lasts exactly N+1 system clocks.
- R4: The serial data output changes only when the serial clock falls. The first bit sent is bit 7 of the data in msb-first order and bit 0 in lsb-first order, and later bits follow in that order.
- R5: Input data is sampled on each rising clock edge and shifted in. After 8 bits the data register holds them, with the first bit received at bit 7 (msb-first) or bit 0 (lsb-first). Without byte-pause, bits sent after the eighth are the received bits in the order they arrived.
- R6: A transfer moves exactly count+1 bits. Hardware then clears run, sets done and drives the interrupt high.
- R7: Done is sticky. Writing control with bit7 = 1 clears it, and writing control with bit7 = 0 leaves it set.
- R8: In byte-pause mode, after each eighth bit that is not the last, hardware clears run without setting done. The clock then stays high until run is written again, and the transfer resumes with the following bit.
- R9: In slave mode the clock output enable is 0. Edges of the external clock, after synchronisation, shift data in the same way as R4 and R5.
- R10: While run is 0, external clock edges have no effect on the data register or the data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| sck_in | input | 1 | External serial clock (slave mode) |
| sck_out | output | 1 | Generated serial clock (master mode) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | Done interrupt |

## Verification
The bench plays the far end of the link against random divider values, bit orders, block lengths and pause settings, and compares every transmitted bit and every received byte with its own model. It targets several corner cases, each of which a faulty design would expose:
- Divider value 0 would show up a half period that is off by one.
- Divider value 255 would show up a divider that wraps early.
- A bit count that is not a multiple of eight would show up a transfer that stops a bit early or late.
- Block transfers longer than one byte without pause would show up echo data that comes out in the wrong order.
- At byte-pause boundaries, a design that sets done early or lets the clock drop during the pause would be caught.
- In slave mode, a design would be caught if it misses synchronised edges, or shifts while idle when the external clock toggles.

// File: rtl/clkser_port.sv
module clkser_port #(
  parameter int CW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sck_oe,
  input  logic       sdi,
  output logic       sdo,
  output logic       irq
);
  logic          run, master, msb, pause, done;
  logic [7:0]    div, dcnt, shreg;
  logic [CW-1:0] bcnt;
  logic [2:0]    bpos;
  logic          sck_q, sdo_q, sck_prev;
  logic [1:0]    sck_sy, sdi_sy;

  wire wr_ctl = reg_wr && reg_addr == 2'd0;
  wire wr_div = reg_wr && reg_addr == 2'd1;
  wire wr_cnt = reg_wr && reg_addr == 2'd2;
  wire wr_dat = reg_wr && reg_addr == 2'd3;

  wire tgl     = run && master && dcnt == div;
  wire fall_ev = master ? (tgl && sck_q)  : (run && !sck_sy[1] && sck_prev);
  wire rise_ev = master ? (tgl && !sck_q) : (run && sck_sy[1] && !sck_prev);
  wire rx_bit  = master ? sdi : sdi_sy[1];
  wire out_bit = msb ? shreg[7] : shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; master <= 1'b0; msb <= 1'b0; pause <= 1'b0; done <= 1'b0;
      div <= '0; dcnt <= '0; shreg <= '0; bcnt <= '0; bpos <= '0;
      sck_q <= 1'b1; sdo_q <= 1'b1; sck_prev <= 1'b1;
      sck_sy <= 2'b11; sdi_sy <= 2'b00;
    end else begin
      sck_sy   <= {sck_sy[0], sck_in};
      sdi_sy   <= {sdi_sy[0], sdi};
      sck_prev <= sck_sy[1];
      dcnt     <= (run && master && dcnt != div) ? dcnt + 8'd1 : 8'd0;
      if (!run || !master) sck_q <= 1'b1;
      else if (tgl)        sck_q <= !sck_q;
      if (fall_ev) sdo_q <= out_bit;
      if (wr_ctl) begin
        run    <= reg_wdata[0];
        master <= reg_wdata[1];
        msb    <= reg_wdata[2];
        pause  <= reg_wdata[3];
        if (reg_wdata[7]) done <= 1'b0;
      end
      if (wr_div) div <= reg_wdata;
      if (wr_cnt) begin
        bcnt <= CW'(reg_wdata);
        bpos <= '0;
      end
      if (wr_dat) shreg <= reg_wdata;
      if (rise_ev) begin
        shreg <= msb ? {shreg[6:0], rx_bit} : {rx_bit, shreg[7:1]};
        bpos  <= bpos + 3'd1;
        if (bcnt == '0) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          bcnt <= bcnt - 1'b1;
          if (pause && bpos == 3'd7) run <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {done, 3'b000, pause, msb, master, run};
      2'd1:    reg_rdata = div;
      2'd2:    reg_rdata = 8'(bcnt);
      default: reg_rdata = shreg;
    endcase
  end

  assign sck_out = sck_q;
  assign sck_oe  = master;
  assign sdo     = sdo_q;
  assign irq     = done;
endmodule

// File: rtl/clkser_port_chk.sv
module clkser_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       done,
  input logic       sck_out,
  input logic       sck_oe,
  input logic       sdo,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] div
);
  logic       prev_sck;
  logic [8:0] hc;
  wire act = run && sck_oe;
  wire tog = sck_out != prev_sck;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sck <= 1'b1;
      hc       <= '0;
    end else begin
      prev_sck <= sck_out;
      hc       <= !act ? 9'd0 : (tog ? 9'd1 : hc + 9'd1);
    end
  end

  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> sck_out); // R3
  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (tog && $past(act)) |-> (hc == {1'b0, div} + 9'd1)); // R3
  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_oe && $past(sck_oe) && sdo != $past(sdo)) |-> (!sck_out && $past(sck_out))); // R4
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !run); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(reg_wr && reg_addr == 2'd0 && reg_wdata[7])) |=> done); // R7
endmodule

bind clkser_port clkser_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .done(done), .sck_out(sck_out),
  .sck_oe(sck_oe), .sdo(sdo), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .div(div)
);

// File: tb/clkser_port_bench.sv
`timescale 1ns/1ps
module clkser_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sck_in = 1'b1;
  logic       sck_out, sck_oe, sdo, irq, sdi;
  logic       sdi_m = 1'b0, sdi_s = 1'b0;

  always #2 clk = ~clk;
  assign sdi = sck_oe ? sdi_m : sdi_s;

  clkser_port u_clkser_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo), .irq(irq)
  );

  int checks = 0, fails = 0, mchecks = 0, mfails = 0;
  logic txs [0:63];
  logic rxs [0:63];
  int   base = 0, rises = 0, hp = 0;
  logic psck = 1'b1;
  int   cur_div = 0;

  function automatic logic bitof(logic [7:0] d, int i, bit m);
    return m ? d[7-i] : d[i];
  endfunction

  function automatic logic [7:0] rxbyte(int start, bit m);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (m) r[7-i] = rxs[start+i];
      else   r[i]   = rxs[start+i];
    end
    return r;
  endfunction

  // far-end model for master mode: drive sdi on falling edges, check sdo and half period
  always @(negedge clk) begin
    if (rst_n && sck_oe) begin
      hp = hp + 1;
      if (psck && !sck_out) begin
        automatic int k = rises - base;
        if (k >= 0 && k < 64) begin
          sdi_m = rxs[k];
          mchecks++;
          if (sdo !== txs[k]) begin
            mfails++;
            $display("FAIL R4 bit %0d: sdo got %0b expected %0b", k, sdo, txs[k]);
          end
        end
        hp = 0;
      end
      if (!psck && sck_out) begin
        mchecks++;
        if (hp != cur_div + 1) begin
          mfails++;
          $display("FAIL R3 half period: got %0d expected %0d", hp, cur_div + 1);
        end
        rises++;
      end
    end
    psck = sck_out;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] d;
    int n = 0;
    rd(2'd0, d);
    while (d[0] && n < 20000) begin
      rd(2'd0, d);
      n++;
    end
    if (d[0]) chk("R6 transfer finishes", 1, 0);
  endtask

  task automatic xfer_master(int n, bit m, int nbytes, bit pz);
    logic [7:0] db [4];
    logic [7:0] d;
    int total = nbytes * 8;
    logic [7:0] ctl = 8'h83 | (pz ? 8'h08 : 8'h00) | (m ? 8'h04 : 8'h00);
    for (int b = 0; b < 4; b++) db[b] = 8'($urandom);
    for (int k = 0; k < total; k++) begin
      rxs[k] = 1'($urandom);
      if (pz || k < 8) txs[k] = bitof(db[k/8], k % 8, m);
      else             txs[k] = rxs[k-8];
    end
    cur_div = n;
    wr(2'd1, 8'(n));
    wr(2'd2, 8'(total - 1));
    base = rises;
    if (!pz) begin
      wr(2'd3, db[0]);
      wr(2'd0, ctl);
      wait_idle();
      chk("R6 bits moved", rises - base, total);
      chk("R6 irq at end", int'(irq), 1);
      rd(2'd3, d);
      chk("R5 received byte", int'(d), int'(rxbyte(total - 8, m)));
    end else begin
      for (int b = 0; b < nbytes; b++) begin
        wr(2'd3, db[b]);
        wr(2'd0, ctl);
        wait_idle();
        rd(2'd3, d);
        chk("R5 received byte in pause mode", int'(d), int'(rxbyte(b * 8, m)));
        chk("R8 bits so far", rises - base, (b + 1) * 8);
        chk("R8 done only at end", int'(irq), (b == nbytes - 1) ? 1 : 0);
        if (b != nbytes - 1) begin
          repeat (2 * (n + 1) + 3) @(negedge clk);
          chk("R8 clock held high in pause", int'(sck_out), 1);
          chk("R8 no extra bits in pause", rises - base, (b + 1) * 8);
        end
      end
    end
    chk("R3 clock idle high", int'(sck_out), 1);
  endtask

  task automatic xfer_slave(bit m);
    logic [7:0] d = 8'($urandom);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) rxs[k] = 1'($urandom);
    wr(2'd2, 8'd7);
    wr(2'd3, d);
    wr(2'd0, 8'h81 | (m ? 8'h04 : 8'h00));
    chk("R9 clock output disabled", int'(sck_oe), 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sck_in = 1'b0;
      sdi_s  = rxs[i];
      repeat (8) @(negedge clk);
      chk("R9 slave sdo bit", int'(sdo), int'(bitof(d, i, m)));
      sck_in = 1'b1;
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(2'd0, r);
    chk("R9 slave ends with done", int'(r), 8'h80 | (m ? 8'h04 : 8'h00));
    rd(2'd3, r);
    chk("R9 slave received byte", int'(r), int'(rxbyte(0, m)));
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks + mchecks + 1, fails + mfails + 1);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic s0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd(2'd0, d);
    chk("R1 control reset", int'(d), 0);
    chk("R1 sck_out reset", int'(sck_out), 1);
    chk("R1 sck_oe reset", int'(sck_oe), 0);
    chk("R1 sdo reset", int'(sdo), 1);
    chk("R1 irq reset", int'(irq), 0);
    // R2
    wr(2'd1, 8'hA5); rd(2'd1, d); chk("R2 divider readback", int'(d), 8'hA5);
    wr(2'd2, 8'h3C); rd(2'd2, d); chk("R2 count readback", int'(d), 8'h3C);
    wr(2'd3, 8'h5A); rd(2'd3, d); chk("R2 data readback", int'(d), 8'h5A);
    wr(2'd0, 8'h0E); rd(2'd0, d); chk("R2 control readback", int'(d), 8'h0E);
    chk("R3 master enables clock output", int'(sck_oe), 1);
    wr(2'd0, 8'h00);
    // directed: divider 0, and 255
    xfer_master(0, 1'b1, 1, 1'b0);
    xfer_master(255, 1'b0, 1, 1'b0);
    // R7
    wr(2'd0, 8'h02); chk("R7 done kept on write with bit7 low", int'(irq), 1);
    wr(2'd0, 8'h80); chk("R7 done cleared on write with bit7 high", int'(irq), 0);
    // odd bit count: 3 bits
    for (int k = 0; k < 3; k++) rxs[k] = 1'($urandom);
    txs[0] = 1'b1; txs[1] = 1'b0; txs[2] = 1'b1;
    cur_div = 1;
    wr(2'd1, 8'd1); wr(2'd2, 8'd2); wr(2'd3, 8'hA0);
    base = rises;
    wr(2'd0, 8'h87);
    wait_idle();
    chk("R6 three-bit transfer", rises - base, 3);
    chk("R6 irq after three bits", int'(irq), 1);
    // random mix
    for (int t = 0; t < 14; t++)
      xfer_master(int'($urandom % 4), 1'($urandom), 1 + int'($urandom % 3), 1'($urandom));
    // slave
    xfer_slave(1'b1);
    xfer_slave(1'b0);
    // R10: idle slave ignores clock
    wr(2'd3, 8'hC3);
    wr(2'd0, 8'h80);
    s0 = sdo;
    rd(2'd3, d);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); sck_in = 1'b0; sdi_s = ~sdi_s;
      repeat (6) @(negedge clk); sck_in = 1'b1;
      repeat (6) @(negedge clk);
    end
    rd(2'd3, d2);
    chk("R10 data unchanged while idle", int'(d2), int'(d));
    chk("R10 sdo unchanged while idle", int'(sdo), int'(s0));
    chk("R10 no done while idle", int'(irq), 0);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks + mchecks, fails + mfails);
    $finish;
  end
endmodule